// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block keeps two 32-bit registers that together decide whether the processor is interrupted: a status register that collects requests from peripherals, and a mask register that selects which of those requests may reach the processor. Peripherals signal a request with a single-cycle pulse on their line of `req_pulse`. The pulse sets the matching status bit on the next clock edge. The DMA controller uses line 3 in the same way as any other source. The single `irq_out` line is high whenever at least one status bit is set and also enabled in the mask.

Software reaches the registers through a small register bus with 16-bit and 32-bit accesses. The status register sits at offset 0x070 and the mask register at offset 0x074. Software acknowledges by writing the status register. The value written acts as an AND mask, and the current mask register also takes part in that AND. Any bit that software writes as 0, and any bit that is disabled in the mask, is therefore cleared by an acknowledge.

Two sources, the serial port and the sound unit, hold level requests rather than pulses. Each acknowledge write forces their bits (7 and 9) to 1 before the AND whenever their level input is high. Writing the mask produces a one-cycle check pulse when a request is already waiting under the new mask.

Top module: `irq_status_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, both registers read 0 and `irq_out` and `chk_pulse` are 0.
- R2: A 1 on bit i of `req_pulse` sets status bit i at that clock edge, and the other bits keep their values. Bit 3 (the DMA source) behaves the same way.
- R3: A 32-bit write to offset 0x070 gives new_status = (old_status | forced) & mask & `bus_wdata`. Here forced is the set of level-held bits described in R4.
- R4: In a status write, bit 7 is forced to 1 when `lvl_serial` is high and bit 9 when `lvl_sound` is high, before the AND. The level inputs have no effect outside status writes.
- R5: A 16-bit status write (`bus_wide`=0) applies the rule of R3 to bits 15:0 only and leaves bits 31:16 unchanged.
- R6: A 32-bit write to 0x074 replaces the mask. A 16-bit write replaces bits 15:0 and keeps bits 31:16.
- R7: `chk_pulse` is high for exactly the one cycle after a mask write, and only if (status before the write) & (new mask) is non-zero. In every other cycle it is low.
- R8: `irq_out` is 1 exactly when status & mask is non-zero, evaluated on the register contents.
- R9: A request pulse in the same cycle as an acknowledge that would clear its bit wins, and the bit ends up set.
- R10: `bus_rdata` returns the status register at 0x070, the mask register at 0x074 and 0 at any other offset. A 16-bit read returns bits 15:0 zero-extended. A write to any other offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register offset within the I/O window |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| req_pulse | input | 32 | Single-cycle request pulses, one per status bit |
| lvl_serial | input | 1 | Level-held serial port request (status bit 7) |
| lvl_sound | input | 1 | Level-held sound request (status bit 9) |
| irq_out | output | 1 | Interrupt to the processor |
| chk_pulse | output | 1 | Pending-check pulse after a mask write |

## Verification
The hardest case to reach is the interaction inside one acknowledge write. A level-held source, its mask bit and its written bit all meet in that write, and a request pulse may land in the same cycle. The bench sweeps every combination of the two level inputs, the two mask bits and the two written bits. Before each sweep point it fills the status register through pulses, so every combination starts from a known full register. Mixed pseudo-random traffic then brings about mask writes over a non-empty status register and narrow accesses against a reference model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int IRQC_REG_W  = 32;
    localparam int IRQC_ADDR_W = 12;
    localparam logic [IRQC_ADDR_W-1:0] IRQC_OFS_STAT = 12'h070;
    localparam logic [IRQC_ADDR_W-1:0] IRQC_OFS_MASK = 12'h074;
    localparam int IRQC_SER_BIT = 7;
    localparam int IRQC_SND_BIT = 9;
    localparam int IRQC_DMA_BIT = 3;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     wide;
        logic     wr;
    } bus_op_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int ADDR_W = IRQC_ADDR_W,
    parameter int REG_W  = IRQC_REG_W,
    parameter logic [ADDR_W-1:0] OFS_STAT = IRQC_OFS_STAT,
    parameter logic [ADDR_W-1:0] OFS_MASK = IRQC_OFS_MASK
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              wide,
    output bus_op_t           op,
    output logic [REG_W-1:0]  lanes
);
    localparam int HALF_W = REG_W / 2;

    always_comb begin
        op.wr   = wr;
        op.wide = wide;
        if (addr == OFS_STAT)      op.sel = SEL_STAT;
        else if (addr == OFS_MASK) op.sel = SEL_MASK;
        else                       op.sel = SEL_NONE;
    end

    assign lanes = wide ? {REG_W{1'b1}} : {{(REG_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
endmodule

// File: rtl/irqc_status_reg.sv
module irqc_status_reg #(
    parameter int REG_W   = 32,
    parameter int SER_BIT = 7,
    parameter int SND_BIT = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack_en,
    input  logic [REG_W-1:0] lanes,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] mask,
    input  logic [REG_W-1:0] req,
    input  logic             lvl_ser,
    input  logic             lvl_snd,
    output logic [REG_W-1:0] stat_q
);
    logic [REG_W-1:0] forced;
    logic [REG_W-1:0] acked;
    logic [REG_W-1:0] stat_d;

    always_comb begin
        forced = stat_q;
        forced[SER_BIT] = stat_q[SER_BIT] | lvl_ser;
        forced[SND_BIT] = stat_q[SND_BIT] | lvl_snd;
        acked = forced & mask & wdata;
        if (ack_en) stat_d = (acked & lanes) | (stat_q & ~lanes);
        else        stat_d = stat_q;
        stat_d = stat_d | req;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] lanes,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] stat,
    output logic [REG_W-1:0] mask_q,
    output logic             chk_q
);
    logic [REG_W-1:0] mask_d;

    always_comb begin
        if (wr_en) mask_d = (wdata & lanes) | (mask_q & ~lanes);
        else       mask_d = mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            chk_q  <= 1'b0;
        end else begin
            mask_q <= mask_d;
            chk_q  <= wr_en && ((stat & mask_d) != '0);
        end
    end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irqc_pkg::*;
#(
    parameter int ADDR_W  = IRQC_ADDR_W,
    parameter int REG_W   = IRQC_REG_W,
    parameter int SER_BIT = IRQC_SER_BIT,
    parameter int SND_BIT = IRQC_SND_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [REG_W-1:0]  req_pulse,
    input  logic              lvl_serial,
    input  logic              lvl_sound,
    output logic              irq_out,
    output logic              chk_pulse
);
    bus_op_t          op;
    logic [REG_W-1:0] lanes;
    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] mask_q;
    logic             wr_stat;
    logic             wr_mask;
    logic [REG_W-1:0] rd_full;

    irqc_decode #(
        .ADDR_W(ADDR_W),
        .REG_W (REG_W)
    ) u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .wide (bus_wide),
        .op   (op),
        .lanes(lanes)
    );

    assign wr_stat = op.wr && (op.sel == SEL_STAT);
    assign wr_mask = op.wr && (op.sel == SEL_MASK);

    irqc_status_reg #(
        .REG_W  (REG_W),
        .SER_BIT(SER_BIT),
        .SND_BIT(SND_BIT)
    ) u_stat (
        .clk    (clk),
        .rst    (rst),
        .ack_en (wr_stat),
        .lanes  (lanes),
        .wdata  (bus_wdata),
        .mask   (mask_q),
        .req    (req_pulse),
        .lvl_ser(lvl_serial),
        .lvl_snd(lvl_sound),
        .stat_q (stat_q)
    );

    irqc_mask_reg #(
        .REG_W(REG_W)
    ) u_mask (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_mask),
        .lanes (lanes),
        .wdata (bus_wdata),
        .stat  (stat_q),
        .mask_q(mask_q),
        .chk_q (chk_pulse)
    );

    always_comb begin
        case (op.sel)
            SEL_STAT: rd_full = stat_q;
            SEL_MASK: rd_full = mask_q;
            default:  rd_full = '0;
        endcase
    end

    assign bus_rdata = rd_full & lanes;
    assign irq_out   = (stat_q & mask_q) != '0;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] req_pulse,
    input logic             bus_wide,
    input logic [REG_W-1:0] bus_wdata,
    input logic             chk_pulse,
    input logic [REG_W-1:0] stat_q,
    input logic [REG_W-1:0] mask_q,
    input logic             wr_stat,
    input logic             wr_mask
);
    localparam int HALF_W = REG_W / 2;

    AST_REQ_LATCH: assert property (@(posedge clk) disable iff (rst)
        (req_pulse != '0) |=> ((stat_q & $past(req_pulse)) == $past(req_pulse))); // R2

    AST_ACK_WITHIN_MASK: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && bus_wide && req_pulse == '0) |=> ((stat_q & ~$past(mask_q)) == '0)); // R3

    AST_NARROW_ACK_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !bus_wide && req_pulse == '0) |=> $stable(stat_q[REG_W-1:HALF_W])); // R5

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_mask && bus_wide) |=> (mask_q == $past(bus_wdata))); // R6

    AST_CHK_AFTER_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
        chk_pulse |-> $past(wr_mask)); // R7

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_stat && req_pulse == '0) |=> $stable(stat_q)); // R10
endmodule

bind irq_status_ctrl irqc_checker #(.REG_W(REG_W)) u_irqc_chk (
    .clk      (clk),
    .rst      (rst),
    .req_pulse(req_pulse),
    .bus_wide (bus_wide),
    .bus_wdata(bus_wdata),
    .chk_pulse(chk_pulse),
    .stat_q   (stat_q),
    .mask_q   (mask_q),
    .wr_stat  (wr_stat),
    .wr_mask  (wr_mask)
);

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] bus_addr;
    logic        bus_wr;
    logic        bus_wide;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] req_pulse;
    logic        lvl_serial;
    logic        lvl_sound;
    logic        irq_out;
    logic        chk_pulse;

    int tests = 0;
    int fails = 0;
    logic [31:0] ms = '0;   // bench model of status
    logic [31:0] mm = '0;   // bench model of mask
    logic        m_chk = 1'b0;

    always #5 clk = ~clk;

    irq_status_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_pulse(req_pulse), .lvl_serial(lvl_serial), .lvl_sound(lvl_sound),
        .irq_out(irq_out), .chk_pulse(chk_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_wr = 1'b0; bus_wide = 1'b1; bus_addr = 12'h070;
        bus_wdata = '0; req_pulse = '0; lvl_serial = 1'b0; lvl_sound = 1'b0;
    endtask

    task automatic readback(input string req);
        check({req, " irq_out R8"}, {31'd0, irq_out}, {31'd0, (ms & mm) != 0});
        check({req, " chk_pulse R7"}, {31'd0, chk_pulse}, {31'd0, m_chk});
        bus_wide = 1'b1; bus_addr = 12'h070; #1;
        check({req, " status R10"}, bus_rdata, ms);
        bus_addr = 12'h074; #1;
        check({req, " mask R10"}, bus_rdata, mm);
        bus_wide = 1'b0; #1;
        check({req, " narrow mask R10"}, bus_rdata, {16'd0, mm[15:0]});
        bus_wide = 1'b1;
    endtask

    // One bus cycle followed by a full readback against the model.
    task automatic step(input string req, input logic [11:0] a, input logic w, input logic wd,
                        input logic [31:0] d, input logic [31:0] rq,
                        input logic ls, input logic ln);
        logic [31:0] ln_mask, forced, ms_n, mm_n;
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wide = wd; bus_wdata = d;
        req_pulse = rq; lvl_serial = ls; lvl_sound = ln;
        ln_mask = wd ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        ms_n = ms; mm_n = mm; m_chk = 1'b0;
        if (w && a == 12'h070) begin
            forced = ms | ({31'd0, ls} << 7) | ({31'd0, ln} << 9);
            ms_n = ((forced & mm & d) & ln_mask) | (ms & ~ln_mask);
        end
        if (w && a == 12'h074) begin
            mm_n = (d & ln_mask) | (mm & ~ln_mask);
            m_chk = (ms & mm_n) != 0;
        end
        ms_n = ms_n | rq;
        @(negedge clk);
        idle();
        ms = ms_n; mm = mm_n;
        readback(req);
        m_chk = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        readback("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        readback("R1 after reset");

        // R2: every request line on its own, with mask all enabled
        step("R6 mask all", 12'h074, 1, 1, 32'hFFFF_FFFF, 0, 0, 0);
        for (int i = 0; i < 32; i++) begin
            step("R2 pulse", 12'h000, 0, 1, 0, 32'd1 << i, 0, 0);
            step("R3 clear", 12'h070, 1, 1, 32'd0, 0, 0, 0);
        end
        step("R2 DMA bit 3", 12'h000, 0, 1, 0, 32'h8, 0, 0);

        // R3/R4: sweep level inputs, mask and written bits 7 and 9
        for (int c = 0; c < 64; c++) begin
            logic [31:0] mk, wv;
            mk = 32'hFFFF_FFFF & ~(32'h280);
            mk = mk | ({31'd0, c[2]} << 7) | ({31'd0, c[3]} << 9);
            wv = 32'h5555_AAAA | ({31'd0, c[4]} << 7) | ({31'd0, c[5]} << 9);
            wv = wv & ~({31'd0, !c[4]} << 7) & ~({31'd0, !c[5]} << 9);
            step("R6 mask", 12'h074, 1, 1, mk, 0, 0, 0);
            step("R3 clear", 12'h070, 1, 1, 32'd0, 0, 0, 0);
            step("R4 level ack", 12'h070, 1, 1, wv, 0, c[0], c[1]);
            step("R4 level idle", 12'h000, 0, 1, 0, 0, 1, 1);
            step("R2 fill", 12'h000, 0, 1, 0, 32'hFFFF_FFFF, 0, 0);
            step("R3 ack", 12'h070, 1, 1, wv, 0, c[0], c[1]);
        end

        // R5/R6: narrow accesses
        step("R6 mask all", 12'h074, 1, 1, 32'hFFFF_FFFF, 0, 0, 0);
        step("R2 fill", 12'h000, 0, 1, 0, 32'hFFFF_FFFF, 0, 0);
        step("R5 narrow ack", 12'h070, 1, 0, 32'h1234_0F0F, 0, 0, 0);
        step("R6 narrow mask", 12'h074, 1, 0, 32'hABCD_00F0, 0, 0, 0);
        step("R5 narrow ack masked", 12'h070, 1, 0, 32'h0000_FFFF, 0, 1, 0);

        // R7: mask write over empty status, then over pending status
        step("R3 clear", 12'h070, 1, 1, 32'd0, 0, 0, 0);
        step("R7 no pending", 12'h074, 1, 1, 32'hFFFF_FFFF, 0, 0, 0);
        step("R2 set", 12'h000, 0, 1, 0, 32'h0001_0000, 0, 0);
        step("R7 disjoint mask", 12'h074, 1, 1, 32'h0000_FFFF, 0, 0, 0);
        step("R7 matching mask", 12'h074, 1, 1, 32'h0001_0000, 0, 0, 0);

        // R9: request wins over a clearing acknowledge
        step("R9 collide", 12'h070, 1, 1, 32'd0, 32'h0001_0020, 0, 0);

        // R10: writes to other offsets change nothing, reads return 0
        for (int o = 0; o < 256; o += 2) begin
            if (o != 12'h070 && o != 12'h074) begin
                step("R10 other offset", o[11:0], 1, 1, 32'h0, 0, 1, 1);
                bus_addr = o[11:0]; #1;
                check("R10 other read", bus_rdata, 32'd0);
                bus_addr = 12'h070;
            end
        end

        // Mixed traffic
        lfsr = 32'hACE1_2468;
        for (int k = 0; k < 400; k++) begin
            logic [11:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr[0] ? 12'h070 : (lfsr[1] ? 12'h074 : 12'h078);
            step("R3 mixed", a, lfsr[2], lfsr[3], lfsr ^ {lfsr[15:0], lfsr[31:16]},
                 lfsr[4] ? (32'd1 << lfsr[9:5]) : 32'd0, lfsr[10], lfsr[11]);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule